// File: doc/BRIEF.md
# Dual-Phase PWM Duty Encoder

The encoder turns a signed 8-bit measurement into an active-low pulse on a single PWM pin. An external square wave `sync_in` sets its timing. A SYNC-high half-period always serves channel 1, and a SYNC-low half-period always serves channel 2. Each channel takes its own sample and its own offset trim, and it produces one low pulse at the start of each of its half-periods.

The pulse width is a fraction of that channel's half-period length. The length is counted in clock cycles over the most recent complete half-period of the same SYNC level. The fraction is one fifth at a zero input and runs linearly from one tenth at negative full scale to three tenths at positive full scale. Because each channel is timed from its own earlier half-period, a SYNC wave with unequal high and low times still gives the right duty on each channel. A fault input forces the pin to its inactive high level. Two flags go with the pin: one shows which channel is being served, and one marks the start of each full SYNC cycle.

Top module: `dpwm_encoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pwm_n` is 1, `cycle_start` is 0 and `chan1_active` is 0.
- R2: `chan1_active` equals the level of `sync_in` as registered on the previous clock edge, so 1 means channel 1 (SYNC high) is served. `cycle_start` is high for exactly one cycle, in the cycle after the clock edge that first samples `sync_in` high.
- R3: A half-period starts at the clock edge that samples a new `sync_in` level. From the next cycle, `pwm_n` is low for W cycles, where W = floor(L*(254+v)/1270), L is the length in cycles of the previous complete half-period at the same SYNC level, and v is the effective input described in R5.
- R4: The effective input v = 0 gives 20% low time, v = +127 gives 30%, and v = -127 gives 10% (for L = 100 the pulse is 20, 30 and 10 cycles).
- R5: A sample of -128 is first treated as -127. The sum of the sample and the offset is then saturated to the range -127..+127 to give v.
- R6: Channel 1 uses only `samp_ch1` and `offs_ch1`. Channel 2 uses only `samp_ch2` and `offs_ch2`.
- R7: The sample and offset are taken only on the clock edge that starts their channel's half-period. Later changes during that half-period do not change the pulse width.
- R8: High and low half-periods of different lengths are timed independently. Each channel's width comes from that channel's own previous length.
- R9: When `fault_in` is sampled high at a clock edge, `pwm_n` is 1 in the following cycle.
- R10: `pwm_n` stays high after reset until both half-period lengths have been measured. The first possible pulse starts at the fourth SYNC edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_in | input | 1 | SYNC square wave, level selects channel |
| samp_ch1 | input | 8 | Signed sample for channel 1 |
| samp_ch2 | input | 8 | Signed sample for channel 2 |
| offs_ch1 | input | 8 | Signed offset trim for channel 1 |
| offs_ch2 | input | 8 | Signed offset trim for channel 2 |
| fault_in | input | 1 | Forces the output inactive while high |
| pwm_n | output | 1 | Active-low PWM output |
| chan1_active | output | 1 | 1 while channel 1 is served |
| cycle_start | output | 1 | One-cycle pulse at each SYNC-high start |

## Verification
The hardest situation to reach is a half-period whose width depends on a length measured two edges earlier, while the opposite channel has a different length and a different trim. Only a long run of unequal high and low phases, with samples that change during the phase, shows a wrong pairing of length and channel.

The stimulus first runs directed phases of 100 cycles at zero, full-scale and saturating inputs. It then runs a long run of random phase lengths, samples, offsets and occasional faults. Samples are rewritten after every phase start, so any late capture shows up. The bench keeps its own history of phase lengths to predict each pulse.

// File: rtl/pwmenc_pkg.sv
package pwmenc_pkg;

    // Saturate x to the symmetric range -lim..+lim
    function automatic int sym_clamp(input int x, input int lim);
        if (x > lim)
            return lim;
        else if (x < -lim)
            return -lim;
        else
            return x;
    endfunction

    // Channel index: 1 serves the SYNC-high phase, 0 the SYNC-low phase
    localparam int CH_HI = 1;
    localparam int CH_LO = 0;

endpackage

// File: rtl/pwmenc_edge.sv
module pwmenc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic lvl_o,
    output logic start_o,
    output logic edge_o
);
    typedef struct packed {
        logic lvl;
        logic start;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.lvl   = sync_in;
        st_d.start = sync_in & ~st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign lvl_o   = st_q.lvl;
    assign start_o = st_q.start;
    assign edge_o  = sync_in ^ st_q.lvl;
endmodule

// File: rtl/pwmenc_timer.sv
module pwmenc_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic             ended_hi_i,
    output logic [CNT_W-1:0] len_hi_o,
    output logic [CNT_W-1:0] len_lo_o,
    output logic             armed_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len_hi;
        logic [CNT_W-1:0] len_lo;
        logic             val_hi;
        logic             val_lo;
        logic             seen;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (edge_i) begin
            st_d.cnt  = CNT_ONE;
            st_d.seen = 1'b1;
            if (st_q.seen) begin
                if (ended_hi_i) begin
                    st_d.len_hi = st_q.cnt;
                    st_d.val_hi = 1'b1;
                end else begin
                    st_d.len_lo = st_q.cnt;
                    st_d.val_lo = 1'b1;
                end
            end
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign len_hi_o = st_q.len_hi;
    assign len_lo_o = st_q.len_lo;
    assign armed_o  = st_q.val_hi & st_q.val_lo;
endmodule

// File: rtl/pwmenc_duty.sv
module pwmenc_duty #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic signed [DATA_W-1:0] samp_i,
    input  logic signed [DATA_W-1:0] offs_i,
    input  logic        [CNT_W-1:0]  len_i,
    output logic        [CNT_W-1:0]  width_o
);
    import pwmenc_pkg::*;

    localparam int FS     = 2 ** (DATA_W - 1) - 1;
    localparam int CENTER = 2 * FS;
    localparam int DEN    = 10 * FS;
    localparam int PROD_W = CNT_W + DATA_W + 1;
    localparam logic [PROD_W-1:0] DEN_P = PROD_W'(DEN);

    int                samp_int;
    int                eff_int;
    logic [DATA_W:0]   num;
    logic [PROD_W-1:0] prod;

    always_comb begin
        samp_int = sym_clamp(int'(samp_i), FS);
        eff_int  = sym_clamp(samp_int + int'(offs_i), FS);
        num      = (DATA_W + 1)'(CENTER + eff_int);
        prod     = {{(DATA_W + 1){1'b0}}, len_i} * {{CNT_W{1'b0}}, num};
        width_o  = CNT_W'(prod / DEN_P);
    end
endmodule

// File: rtl/pwmenc_pulse.sv
module pwmenc_pulse #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             fault_i,
    output logic             pwm_n_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] rem;
        logic             out_n;
    } pls_st_t;

    pls_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i)
            st_d.rem = load_val_i;
        else if (st_q.rem != '0)
            st_d.rem = st_q.rem - ONE;
        st_d.out_n = fault_i | (st_d.rem == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rem   <= '0;
            st_q.out_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_n_o = st_q.out_n;
endmodule

// File: rtl/dpwm_encoder.sv
module dpwm_encoder #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sync_in,
    input  logic signed [DATA_W-1:0] samp_ch1,
    input  logic signed [DATA_W-1:0] samp_ch2,
    input  logic signed [DATA_W-1:0] offs_ch1,
    input  logic signed [DATA_W-1:0] offs_ch2,
    input  logic                     fault_in,
    output logic                     pwm_n,
    output logic                     chan1_active,
    output logic                     cycle_start
);
    import pwmenc_pkg::*;

    localparam int NCH = 2;

    logic             lvl;
    logic             sync_edge;
    logic             armed;
    logic [CNT_W-1:0] len_ch [NCH];
    logic [CNT_W-1:0] w_ch   [NCH];
    logic [CNT_W-1:0] load_val;

    pwmenc_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .lvl_o   (lvl),
        .start_o (cycle_start),
        .edge_o  (sync_edge)
    );

    pwmenc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_i     (sync_edge),
        .ended_hi_i (lvl),
        .len_hi_o   (len_ch[CH_HI]),
        .len_lo_o   (len_ch[CH_LO]),
        .armed_o    (armed)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwmenc_duty #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_duty (
            .samp_i  ((c == CH_HI) ? samp_ch1 : samp_ch2),
            .offs_i  ((c == CH_HI) ? offs_ch1 : offs_ch2),
            .len_i   (len_ch[c]),
            .width_o (w_ch[c])
        );
    end

    // New level on sync_in picks the channel whose half-period starts now
    always_comb begin
        if (!armed)
            load_val = '0;
        else if (sync_in)
            load_val = w_ch[CH_HI];
        else
            load_val = w_ch[CH_LO];
    end

    pwmenc_pulse #(.CNT_W(CNT_W)) u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sync_edge),
        .load_val_i (load_val),
        .fault_i    (fault_in),
        .pwm_n_o    (pwm_n)
    );

    assign chan1_active = lvl;
endmodule

// File: rtl/dpwm_encoder_chk.sv
module dpwm_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic fault_in,
    input logic pwm_n,
    input logic chan1_active,
    input logic cycle_start,
    input logic armed
);
    // R9
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |=> pwm_n);

    // R2
    start_in_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> $rose(chan1_active));

    // R2
    start_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan1_active) |-> cycle_start);

    // R10
    low_needs_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_n |-> $past(armed));

    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !cycle_start);
endmodule

bind dpwm_encoder dpwm_encoder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_in     (fault_in),
    .pwm_n        (pwm_n),
    .chan1_active (chan1_active),
    .cycle_start  (cycle_start),
    .armed        (armed)
);

// File: tb/dpwm_encoder_test.sv
module dpwm_encoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sync_in = 1'b0;
    logic signed [7:0] samp_ch1 = '0;
    logic signed [7:0] samp_ch2 = '0;
    logic signed [7:0] offs_ch1 = '0;
    logic signed [7:0] offs_ch2 = '0;
    logic              fault_in = 1'b0;
    logic              pwm_n;
    logic              chan1_active;
    logic              cycle_start;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    // Bench history of complete half-period lengths (index 1 = high)
    int  len_b [2];
    bit  val_b [2];
    bit  have_prev = 1'b0;
    bit  prev_lvl  = 1'b0;
    int  prev_n    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dpwm_encoder uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_in      (sync_in),
        .samp_ch1     (samp_ch1),
        .samp_ch2     (samp_ch2),
        .offs_ch1     (offs_ch1),
        .offs_ch2     (offs_ch2),
        .fault_in     (fault_in),
        .pwm_n        (pwm_n),
        .chan1_active (chan1_active),
        .cycle_start  (cycle_start)
    );

    function automatic int clamp127(int x);
        if (x > 127) return 127;
        if (x < -127) return -127;
        return x;
    endfunction

    function automatic int exp_width(int len, int s, int o);
        int v;
        v = clamp127(clamp127(s) + o);
        return (len * (254 + v)) / 1270;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Run one half-period of n cycles at level lvl; s/o feed that level's channel
    task automatic run_phase(input bit lvl, input int n, input int s, input int o,
                             input bit flt, input string req);
        bit armed_b;
        int w_exp;
        int lows;
        armed_b = val_b[0] && val_b[1];
        w_exp = 0;
        if (armed_b && !flt) begin
            w_exp = exp_width(len_b[lvl], s, o);
            if (w_exp > n) w_exp = n;
        end
        if (have_prev) begin
            val_b[prev_lvl] = 1'b1;
            len_b[prev_lvl] = prev_n;
        end
        sync_in  = lvl;
        fault_in = flt;
        if (lvl) begin
            samp_ch1 = 8'(s);
            offs_ch1 = 8'(o);
            samp_ch2 = 8'($urandom);
            offs_ch2 = 8'($urandom);
        end else begin
            samp_ch2 = 8'(s);
            offs_ch2 = 8'(o);
            samp_ch1 = 8'($urandom);
            offs_ch1 = 8'($urandom);
        end
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) begin
                check("R2 chan1_active", int'(chan1_active), int'(lvl));
                check("R2 cycle_start", int'(cycle_start), int'(lvl));
            end
            if (i == 1) begin
                // R7: later changes of inputs must not alter the pulse
                samp_ch1 = 8'($urandom);
                samp_ch2 = 8'($urandom);
                offs_ch1 = 8'($urandom);
                offs_ch2 = 8'($urandom);
            end
            if (!pwm_n) lows++;
        end
        check(req, lows, w_exp);
        have_prev = 1'b1;
        prev_lvl  = lvl;
        prev_n    = n;
    endtask

    initial begin
        bit lvl;
        void'($urandom(32'd20240611));
        val_b[0] = 1'b0; val_b[1] = 1'b0;
        len_b[0] = 0;    len_b[1] = 0;
        repeat (3) @(negedge clk);
        check("R1 pwm_n in reset", int'(pwm_n), 1);
        check("R1 cycle_start in reset", int'(cycle_start), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pwm_n after reset", int'(pwm_n), 1);
        check("R1 chan1_active after reset", int'(chan1_active), 0);
        repeat (4) @(negedge clk);

        // R10: first three half-periods give no pulse
        run_phase(1'b1, 100, 127, 0, 1'b0, "R10 unarmed phase 1");
        run_phase(1'b0, 100, 127, 0, 1'b0, "R10 unarmed phase 2");
        run_phase(1'b1, 100, 127, 0, 1'b0, "R10 unarmed phase 3");
        // R4: centre and full-scale points with L = 100
        run_phase(1'b0, 100,    0,    0, 1'b0, "R4 zero gives 20 percent");
        run_phase(1'b1, 100,  127,    0, 1'b0, "R4 plus full scale 30 percent");
        run_phase(1'b0, 100, -127,    0, 1'b0, "R4 minus full scale 10 percent");
        // R5: -128 and saturating sums
        run_phase(1'b1, 100, -128,    0, 1'b0, "R5 minus 128 clamped");
        run_phase(1'b0, 100,  100,  100, 1'b0, "R5 positive sum saturates");
        run_phase(1'b1, 100, -100, -100, 1'b0, "R5 negative sum saturates");
        // R6: offsets per channel
        run_phase(1'b0, 100,   10,   50, 1'b0, "R6 channel 2 offset");
        run_phase(1'b1, 100,   10,  -50, 1'b0, "R6 channel 1 offset");
        // R9: fault masks the pulse
        run_phase(1'b0, 100,  127,    0, 1'b1, "R9 fault forces high");
        run_phase(1'b1, 100,    0,    0, 1'b0, "R9 recovery after fault");
        // R8: unequal half-periods
        run_phase(1'b0, 160,   50,    0, 1'b0, "R8 long low phase");
        run_phase(1'b1,  40,   50,    0, 1'b0, "R8 short high phase");
        run_phase(1'b0, 160,  -50,    0, 1'b0, "R8 low uses own length");
        run_phase(1'b1,  40,  -50,    0, 1'b0, "R8 high uses own length");

        // R3 R7: constrained random phases
        lvl = 1'b0;
        for (int k = 0; k < 300; k++) begin
            int n;
            int s;
            int o;
            bit f;
            n = 6 + int'($urandom % 75);
            s = int'($urandom % 256) - 128;
            o = ($urandom % 4 == 0) ? int'($urandom % 256) - 128 : int'($urandom % 41) - 20;
            f = ($urandom % 16 == 0);
            run_phase(lvl, n, s, o, f, "R3 random pulse width");
            lvl = ~lvl;
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule